// File: doc/BRIEF.md
# Serial Addressed Multichannel DAC Loader

This block is the digital front end of a ten-channel converter that is loaded over a serial line. Bits arrive one at a time on a one-bit stream input and fill a 14-bit shift register. When the load input is high, the register contents are split into two fields. The upper four bits form a channel address. The lower ten bits form a conversion code, which is written into the holding register of the addressed channel. A mode input chooses which end of the code field carries the most significant bit.

The topmost shift-register bit is driven on a cascade output. Several loaders can therefore be chained, each one's cascade output feeding the next one's serial input. Address codes that name no channel are accepted and have no effect. The all-ones address is kept as a test command, which is also accepted and has no effect. An active-low reset clears the shift register and every channel at once, without waiting for a clock edge.

The serial input is a valid/ready stream. A beat is taken on any rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high whenever reset is released, so the block applies back-pressure only while it is in reset.

Top module: `sdac_loader`

## Requirements
- R1: Each accepted beat enters shift-register bit 0 while the existing bits move one place up. `in_ready` is high exactly when `rst_n` is high.
- R2: `casc_out` carries shift-register bit 13 at all times. After a complete 14-bit word it therefore shows the first bit of that word, and it holds its value in any cycle with no accepted beat.
- R3: Bits 0..9 of the shift register form the code field. Bits 10..13 form the address, read as a 4-bit number with bit 10 as its MSB. Address values 1..10 select channels 1..10. Channel n drives `ch_codes[(n-1)*10 +: 10]`.
- R4: A load sampled high on a rising edge updates only the addressed channel, and the new value is visible after that edge. No channel changes in a cycle where load is low.
- R5: A load with address 0 or with an address from 11 to 14 leaves all ten channels unchanged.
- R6: A load with address 15 (the test command) is accepted and leaves all ten channels unchanged.
- R7: With `msb_first` high, shift-register bit 0 becomes code bit 9 (the MSB) and bit 9 becomes code bit 0.
- R8: With `msb_first` low, shift-register bit k becomes code bit k, so bit 0 is the LSB.
- R9: While `rst_n` is low, all channel codes and the shift register read zero. This takes effect immediately and does not wait for a clock edge.
- R10: Holding load high for several cycles rewrites the same channel with the same code and disturbs no other channel.
- R11: A load in the same cycle as an accepted beat captures the shift-register contents from before that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Serial beat valid |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Serial beat ready; high out of reset |
| load | input | 1 | Load strobe, level sampled on clk |
| msb_first | input | 1 | Code bit order: high selects bit 0 as MSB |
| ch_codes | output | 100 | Ten 10-bit channel codes, channel 1 in the lowest slice |
| casc_out | output | 1 | Cascade output, top shift-register bit |

## Verification
On every cycle, the assertions check four things. Each accepted beat moves the shift register by one place. The cascade output holds when no beat is taken. No more than one channel changes per cycle, and none changes without a load. Loads carrying an unused address or the test command leave every channel unchanged.

Some behaviour can only be shown by the bench's scenarios, where a scoreboard compares all ten channels against a model after each load. These cover the address-to-channel mapping, both bit orders of the code, the cascade bit after whole words and after an extra beat, a load that overlaps a beat, and a reset applied between clock edges.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned DEF_CHANNELS = 10;
  localparam int unsigned DEF_CODE_W   = 10;
  localparam int unsigned DEF_ADDR_W   = 4;
endpackage

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned SW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          bit_in,
  output logic [SW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (beat) q <= {q[SW-2:0], bit_in};
  end
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode #(
  parameter int unsigned NCH = 10,
  parameter int unsigned CW  = 10,
  parameter int unsigned AW  = 4
) (
  input  logic [CW+AW-1:0] word,
  input  logic             msb_first,
  input  logic             load,
  output logic [NCH-1:0]   wr_en,
  output logic [CW-1:0]    code
);
  logic [AW-1:0] addr;
  logic [CW-1:0] flipped;

  // address field: lowest address bit of the word is the numeric MSB
  for (genvar k = 0; k < AW; k++) begin : g_addr
    assign addr[AW-1-k] = word[CW+k];
  end

  for (genvar k = 0; k < CW; k++) begin : g_flip
    assign flipped[k] = word[CW-1-k];
  end

  assign code = msb_first ? flipped : word[CW-1:0];

  // channel c+1 decodes; 0, unused codes and all-ones select nothing
  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign wr_en[c] = load && (addr == AW'(c + 1));
  end
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
  parameter int unsigned NCH = 10,
  parameter int unsigned CW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_en,
  input  logic [CW-1:0]     code,
  output logic [NCH*CW-1:0] codes
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hold_q <= '0;
      else if (wr_en[c]) hold_q <= code;
    end
    assign codes[c*CW +: CW] = hold_q;
  end
endmodule

// File: rtl/sdac_loader.sv
module sdac_loader
  import sdac_pkg::*;
#(
  parameter int unsigned NCH = DEF_CHANNELS,
  parameter int unsigned CW  = DEF_CODE_W,
  parameter int unsigned AW  = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  input  logic              load,
  input  logic              msb_first,
  output logic [NCH*CW-1:0] ch_codes,
  output logic              casc_out
);
  localparam int unsigned SW = CW + AW;

  logic [SW-1:0]  shift_q;
  logic [NCH-1:0] wr_en;
  logic [CW-1:0]  wr_code;
  logic           beat;

  assign in_ready = rst_n;
  assign beat     = in_valid && in_ready;
  assign casc_out = shift_q[SW-1];

  sdac_shift #(.SW(SW)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .bit_in(in_bit),
    .q     (shift_q)
  );

  sdac_decode #(.NCH(NCH), .CW(CW), .AW(AW)) u_dec (
    .word     (shift_q),
    .msb_first(msb_first),
    .load     (load),
    .wr_en    (wr_en),
    .code     (wr_code)
  );

  sdac_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .code (wr_code),
    .codes(ch_codes)
  );
endmodule

// File: rtl/sdac_loader_chk.sv
module sdac_loader_chk #(
  parameter int unsigned NCH = 10,
  parameter int unsigned CW  = 10,
  parameter int unsigned AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_bit,
  input logic              in_ready,
  input logic              load,
  input logic [NCH*CW-1:0] ch_codes,
  input logic              casc_out,
  input logic [CW+AW-1:0]  shift_q
);
  localparam int unsigned SW = CW + AW;

  logic [AW-1:0]     addr_v;
  logic [NCH*CW-1:0] prev_q;
  logic [NCH-1:0]    moved;
  logic              unused_addr;

  always_comb begin
    for (int k = 0; k < AW; k++) addr_v[AW-1-k] = shift_q[CW+k];
  end

  assign unused_addr = (addr_v == '0) || (int'(addr_v) > int'(NCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= ch_codes;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++)
      moved[c] = (ch_codes[c*CW +: CW] != prev_q[c*CW +: CW]);
  end

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (shift_q[0] == $past(in_bit)) &&
                               (shift_q[SW-1:1] == $past(shift_q[SW-2:0])));

  assert_casc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(casc_out));

  assert_one_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(moved) <= 1);

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ch_codes));

  assert_unused_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && unused_addr && (addr_v != '1)) |=> $stable(ch_codes));

  assert_test_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (addr_v == '1)) |=> $stable(ch_codes));
endmodule

bind sdac_loader sdac_loader_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (.*);

// File: tb/tb_sdac_loader.sv
module tb_sdac_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_ready;
  logic        load = 1'b0;
  logic        msb_first = 1'b0;
  logic [99:0] ch_codes;
  logic        casc_out;

  typedef struct {
    int          ch;
    logic [9:0]  code;
    string       req;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  int    model [10];
  bit    done  = 1'b0;

  always #4 clk = ~clk;

  sdac_loader dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .load(load), .msb_first(msb_first),
    .ch_codes(ch_codes), .casc_out(casc_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(int a, int val, bit rev);
    logic [13:0] w;
    for (int k = 0; k < 4; k++)  w[10+k] = a[3-k];
    for (int k = 0; k < 10; k++) w[k] = rev ? val[9-k] : val[k];
    return w;
  endfunction

  task automatic push_all(string req);
    item_t it;
    for (int c = 0; c < 10; c++) begin
      it.ch = c; it.code = 10'(model[c]); it.req = req;
      q.push_back(it);
    end
  endtask

  task automatic send_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk); in_valid = 1'b1; in_bit = w[i];
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pulse_load(int n, int a, int val, string req);
    load = 1'b1;
    repeat (n) @(negedge clk);
    load = 1'b0;
    if (a >= 1 && a <= 10) model[a-1] = val;
    push_all(req);
  endtask

  task automatic write_ch(int a, int val, bit rev, string req);
    logic [13:0] w;
    w = mk(a, val, rev);
    msb_first = rev;
    send_word(w);
    chk("R2 cascade shows first bit", 32'(casc_out), 32'(w[13]));
    pulse_load(1, a, val, req);
  endtask

  // monitor: compares scoreboard items shortly after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        chk(it.req, 32'(ch_codes[it.ch*10 +: 10]), 32'(it.code));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] w;
    for (int c = 0; c < 10; c++) model[c] = 0;
    #3;
    chk("R9 reset codes", 32'(ch_codes == '0), 32'd1);
    chk("R9 reset ready low", 32'(in_ready), 32'd0);
    chk("R9 reset cascade", 32'(casc_out), 32'd0);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(in_ready), 32'd1);

    // R3 R4 R8: LSB-first code order, several channels
    write_ch(1, 10'h001, 1'b0, "R8 ch1");
    write_ch(10, 10'h3FF, 1'b0, "R3 ch10");
    write_ch(5, 10'h2A5, 1'b0, "R4 ch5");
    // R7: MSB-first order
    write_ch(2, 10'h001, 1'b1, "R7 ch2");
    write_ch(7, 10'h0F3, 1'b1, "R7 ch7");
    // R5: unused addresses
    write_ch(0, 10'h155, 1'b0, "R5 addr0");
    write_ch(11, 10'h0AA, 1'b0, "R5 addr11");
    write_ch(14, 10'h3C3, 1'b1, "R5 addr14");
    // R6: test command
    write_ch(15, 10'h1FF, 1'b0, "R6 test cmd");
    // R10: held load
    msb_first = 1'b0;
    w = mk(3, 10'h123, 1'b0);
    send_word(w);
    pulse_load(4, 3, 10'h123, "R10 held load");

    // R1: one extra beat moves the word up by one place
    w = mk(9, 10'h2F0, 1'b0);
    send_word(w);
    @(negedge clk); in_valid = 1'b1; in_bit = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    chk("R1 extra beat shifts", 32'(casc_out), 32'(w[12]));
    repeat (3) @(negedge clk);
    chk("R2 cascade holds idle", 32'(casc_out), 32'(w[12]));

    // R11: load overlapping a beat uses pre-beat contents
    w = mk(4, 10'h0AB, 1'b0);
    send_word(w);
    load = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    @(negedge clk);
    load = 1'b0; in_valid = 1'b0;
    model[3] = 10'h0AB;
    push_all("R11 overlap");
    repeat (2) @(negedge clk);

    // R9: reset between edges clears immediately
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async clear codes", 32'(ch_codes == '0), 32'd1);
    chk("R9 async ready low", 32'(in_ready), 32'd0);
    chk("R9 async cascade", 32'(casc_out), 32'd0);
    for (int c = 0; c < 10; c++) model[c] = 0;
    @(negedge clk); rst_n = 1'b1;
    write_ch(6, 10'h321, 1'b1, "R4 after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule